// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block holds the 16-bit transfer count of a bus controller and works out how many bytes each DMA burst moves. The host programs the count one byte at a time into write-side shadow registers. The readable count registers change only when the host issues a command with the DMA flag set. That command copies the shadow value into the readable count. When the command is a transfer-information command, it also starts a burst.

The burst length is the smaller of two values. The first is the programmed count, where zero stands for 65536. The second is a phase limit. In normal operation the phase limit is the magnitude of a signed residual phase length. While command bytes are being collected, it is a fixed cap of 32 bytes. After a burst starts, the block counts down the bytes the DMA engine acknowledges on each handshake beat. When the count reaches zero, the block raises terminal count and posts a bus-service interrupt code. It also clears the readable count. Moving the data itself is handled elsewhere.

Top module: `dma_len_counter`

## Requirements
- R1: After reset, `count_rd`, `tc_flag`, `dma_mode`, `intr_code`, `xfer_busy`, `remaining` and `burst_len` are all zero.
- R2: A host write at address 0 sets the low count byte of the shadow, and a write at address 1 sets the high byte (little-endian). `count_rd` stays unchanged until a command write at address 3 has bit 7 set. That write copies the shadow into `count_rd` on the same clock edge.
- R3: Any host write to address 0 or 1 clears `tc_flag`, unless a completion happens in the same cycle.
- R4: A command write sets `dma_mode` to bit 7 of the written byte. When bit 7 is clear, no reload takes place.
- R5: A command byte whose low seven bits equal 0x10 and whose bit 7 is set starts a burst, using the freshly reloaded count. On the next edge, `burst_len` becomes min(count, |phase_resid|), where a count of 0 means 65536. At the same time, `remaining` is loaded with that length, `burst_start` pulses high for one cycle and `tc_flag` clears.
- R6: While `cmd_collect` is high, the burst length is min(count, 32).
- R7: The same command code with bit 7 clear starts nothing. `burst_start` stays low and `burst_len` keeps its value.
- R8: Each `beat_valid` cycle during a burst lowers `remaining` by min(`beat_bytes`, `remaining`). Beats that arrive while no burst is active are ignored.
- R9: When `remaining` reaches zero, all of the following happen on that edge:
  - `tc_flag` is set.
  - `intr_code` becomes 0x10.
  - `count_rd` becomes 0.
  - `xfer_busy` drops.
  - `xfer_done` pulses for one cycle.
- R10: A burst whose computed length is zero completes on the same edge that starts it.
- R11: A negative `phase_resid` limits the burst by its absolute value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address (0 low count, 1 high count, 3 command) |
| host_wdata | input | 8 | Host write data |
| cmd_collect | input | 1 | Command-byte collection phase is active |
| phase_resid | input | 18 | Signed residual length of the current phase |
| beat_valid | input | 1 | DMA engine acknowledges a beat |
| beat_bytes | input | 3 | Bytes moved by this beat |
| count_rd | output | 16 | Readable transfer count |
| tc_flag | output | 1 | Terminal-count status bit |
| dma_mode | output | 1 | DMA flag of the last command |
| intr_code | output | 8 | Interrupt code, 0x10 after completion |
| burst_len | output | 17 | Length of the current burst |
| burst_start | output | 1 | One-cycle pulse that starts a burst |
| remaining | output | 17 | Bytes still to move in the burst |
| xfer_busy | output | 1 | Burst in progress |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The burst-length rule is exercised with several inputs, each chosen so that a different term of the minimum wins:
- A small count against a large positive residual, where the count sets the length.
- A large count against a negative residual, where the residual's magnitude sets the length, showing that the sign is dropped.
- A zero count against a residual above 65535, showing that zero is read as 65536.
- Collection mode, tested once with a count above 32 and once with a count below it.
- A zero residual, which gives a zero-length burst and an immediate completion.

Beat sequences whose last beat is larger than what remains show that the decrement saturates. Beats sent while the counter is idle confirm that they leave the counter unchanged.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] ADDR_CNT_LO  = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_CNT_HI  = 4'h1;
    localparam logic [ADDR_W-1:0] ADDR_COMMAND = 4'h3;
    localparam logic [6:0]        OP_XFER_INFO = 7'h10;
    localparam logic [7:0]        INTR_BUS_SVC = 8'h10;
    localparam logic [7:0]        INTR_NONE    = 8'h00;
endpackage

// File: rtl/dlc_count_regs.sv
module dlc_count_regs
    import dlc_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              done_now,
    output logic [CNT_W-1:0]  eff_count,
    output logic              go,
    output logic [CNT_W-1:0]  count_rd,
    output logic              tc_flag,
    output logic              dma_mode,
    output logic [7:0]        intr_code
);
    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] rd;
        logic             tc;
        logic             dma;
        logic [7:0]       intr;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_lo, wr_hi, wr_cmd, dma_bit;

    always_comb begin
        wr_lo     = host_wr && (host_addr == ADDR_CNT_LO);
        wr_hi     = host_wr && (host_addr == ADDR_CNT_HI);
        wr_cmd    = host_wr && (host_addr == ADDR_COMMAND);
        dma_bit   = host_wdata[BYTE_W-1];
        go        = wr_cmd && dma_bit && (host_wdata[6:0] == OP_XFER_INFO);
        eff_count = (wr_cmd && dma_bit) ? regs_q.shadow : regs_q.rd;

        regs_d = regs_q;
        if (wr_lo) regs_d.shadow[BYTE_W-1:0]     = host_wdata;
        if (wr_hi) regs_d.shadow[CNT_W-1:BYTE_W] = host_wdata;
        if (wr_lo || wr_hi) regs_d.tc = 1'b0;
        if (wr_cmd) begin
            regs_d.dma = dma_bit;
            if (dma_bit) regs_d.rd = regs_q.shadow;
        end
        if (go) begin
            regs_d.tc   = 1'b0;
            regs_d.intr = INTR_NONE;
        end
        if (done_now) begin
            regs_d.tc   = 1'b1;
            regs_d.intr = INTR_BUS_SVC;
            regs_d.rd   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign count_rd  = regs_q.rd;
    assign tc_flag   = regs_q.tc;
    assign dma_mode  = regs_q.dma;
    assign intr_code = regs_q.intr;

    // R3: count-byte write clears terminal count
    assert_tc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (host_addr == ADDR_CNT_LO || host_addr == ADDR_CNT_HI) && !done_now)
        |=> !tc_flag);

    // R4: DMA flag follows command bit 7
    assert_dma_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_COMMAND) |=> (dma_mode == $past(host_wdata[BYTE_W-1])));

    // R9: completion posts status
    assert_done_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_now |=> (tc_flag && count_rd == '0 && intr_code == INTR_BUS_SVC));
endmodule

// File: rtl/dlc_burst_calc.sv
module dlc_burst_calc #(
    parameter int CNT_W   = 16,
    parameter int RESID_W = 18,
    parameter int CMD_CAP = 32,
    localparam int LEN_W  = CNT_W + 1,
    localparam int CMP_W  = (LEN_W > RESID_W) ? LEN_W : RESID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   eff_count,
    input  logic               cmd_collect,
    input  logic [RESID_W-1:0] phase_resid,
    output logic [LEN_W-1:0]   len
);
    logic [LEN_W-1:0]   full;
    logic [RESID_W-1:0] mag;
    logic [CMP_W-1:0]   full_x, limit, pick;

    always_comb begin
        full   = (eff_count == '0) ? (LEN_W'(1) << CNT_W) : {1'b0, eff_count};
        mag    = phase_resid[RESID_W-1] ? (~phase_resid + 1'b1) : phase_resid;
        full_x = CMP_W'(full);
        limit  = cmd_collect ? CMP_W'(CMD_CAP) : CMP_W'(mag);
        pick   = (full_x < limit) ? full_x : limit;
        len    = pick[LEN_W-1:0];
    end

    // R6: command collection never exceeds the cap
    assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_collect |-> (len <= LEN_W'(CMD_CAP)));
endmodule

// File: rtl/dlc_beat_tracker.sv
module dlc_beat_tracker #(
    parameter int LEN_W  = 17,
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [LEN_W-1:0]  len,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic              done_now,
    output logic [LEN_W-1:0]  burst_len,
    output logic              burst_start,
    output logic [LEN_W-1:0]  remaining,
    output logic              xfer_busy,
    output logic              xfer_done
);
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             start;
        logic [LEN_W-1:0] rem;
        logic             busy;
        logic             done;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [LEN_W-1:0] beat_x, dec;

    always_comb begin
        beat_x   = LEN_W'(beat_bytes);
        dec      = (beat_x > trk_q.rem) ? trk_q.rem : beat_x;
        done_now = 1'b0;
        trk_d       = trk_q;
        trk_d.start = 1'b0;
        if (go) begin
            trk_d.len   = len;
            trk_d.start = 1'b1;
            trk_d.rem   = len;
            trk_d.busy  = (len != '0);
            done_now    = (len == '0);
        end else if (trk_q.busy && beat_valid) begin
            trk_d.rem = trk_q.rem - dec;
            if (dec == trk_q.rem) begin
                trk_d.busy = 1'b0;
                done_now   = 1'b1;
            end
        end
        trk_d.done = done_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign burst_len   = trk_q.len;
    assign burst_start = trk_q.start;
    assign remaining   = trk_q.rem;
    assign xfer_busy   = trk_q.busy;
    assign xfer_done   = trk_q.done;

    // R8: no beat, no change
    assert_rem_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && !beat_valid && !go) |=> $stable(remaining));

    // R8: remaining never exceeds the burst length
    assert_rem_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        remaining <= burst_len);

    // R5: a start loads the full length
    assert_start_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (burst_start && remaining == burst_len));
endmodule

// File: rtl/dma_len_counter.sv
module dma_len_counter
    import dlc_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int RESID_W = 18,
    parameter int BEAT_W  = 3,
    parameter int CMD_CAP = 32,
    localparam int CNT_W  = 2 * BYTE_W,
    localparam int LEN_W  = CNT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [BYTE_W-1:0]  host_wdata,
    input  logic               cmd_collect,
    input  logic [RESID_W-1:0] phase_resid,
    input  logic               beat_valid,
    input  logic [BEAT_W-1:0]  beat_bytes,
    output logic [CNT_W-1:0]   count_rd,
    output logic               tc_flag,
    output logic               dma_mode,
    output logic [7:0]         intr_code,
    output logic [LEN_W-1:0]   burst_len,
    output logic               burst_start,
    output logic [LEN_W-1:0]   remaining,
    output logic               xfer_busy,
    output logic               xfer_done
);
    logic [CNT_W-1:0] eff_count;
    logic [LEN_W-1:0] len;
    logic             go, done_now;

    dlc_count_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .done_now(done_now), .eff_count(eff_count),
        .go(go), .count_rd(count_rd), .tc_flag(tc_flag), .dma_mode(dma_mode),
        .intr_code(intr_code)
    );

    dlc_burst_calc #(.CNT_W(CNT_W), .RESID_W(RESID_W), .CMD_CAP(CMD_CAP)) u_calc (
        .clk(clk), .rst_n(rst_n), .eff_count(eff_count), .cmd_collect(cmd_collect),
        .phase_resid(phase_resid), .len(len)
    );

    dlc_beat_tracker #(.LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .go(go), .len(len), .beat_valid(beat_valid),
        .beat_bytes(beat_bytes), .done_now(done_now), .burst_len(burst_len),
        .burst_start(burst_start), .remaining(remaining), .xfer_busy(xfer_busy),
        .xfer_done(xfer_done)
    );
endmodule

// File: tb/tb_dma_len_counter.sv
module tb_dma_len_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        cmd_collect = 1'b0;
    logic [17:0] phase_resid = '0;
    logic        beat_valid = 1'b0;
    logic [2:0]  beat_bytes = '0;
    logic [15:0] count_rd;
    logic        tc_flag, dma_mode, burst_start, xfer_busy, xfer_done;
    logic [7:0]  intr_code;
    logic [16:0] burst_len, remaining;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dma_len_counter dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .cmd_collect(cmd_collect), .phase_resid(phase_resid),
        .beat_valid(beat_valid), .beat_bytes(beat_bytes), .count_rd(count_rd),
        .tc_flag(tc_flag), .dma_mode(dma_mode), .intr_code(intr_code),
        .burst_len(burst_len), .burst_start(burst_start), .remaining(remaining),
        .xfer_busy(xfer_busy), .xfer_done(xfer_done)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic beat(input logic [2:0] b);
        @(negedge clk);
        beat_valid = 1'b1; beat_bytes = b;
        @(negedge clk);
        beat_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 count_rd", count_rd, 0);
        chk("R1 tc_flag", tc_flag, 0);
        chk("R1 dma_mode", dma_mode, 0);
        chk("R1 intr_code", intr_code, 0);
        chk("R1 xfer_busy", xfer_busy, 0);
        chk("R1 remaining", remaining, 0);
        chk("R1 burst_len", burst_len, 0);
    endtask

    task automatic t_shadow;
        hwrite(4'h0, 8'h34);
        hwrite(4'h1, 8'h12);
        chk("R2 shadow hidden", count_rd, 0);
        hwrite(4'h3, 8'h00);
        chk("R4 no reload without bit7", count_rd, 0);
        chk("R4 dma_mode low", dma_mode, 0);
        hwrite(4'h3, 8'h80);
        chk("R2 reload little-endian", count_rd, 16'h1234);
        chk("R4 dma_mode high", dma_mode, 1);
    endtask

    task automatic t_burst_complete;
        phase_resid = 18'd100;
        hwrite(4'h0, 8'd10);
        hwrite(4'h1, 8'd0);
        hwrite(4'h3, 8'h90);
        chk("R5 start pulse", burst_start, 1);
        chk("R5 len=count", burst_len, 10);
        chk("R5 remaining loaded", remaining, 10);
        chk("R5 busy", xfer_busy, 1);
        beat(3'd4);
        chk("R5 start one cycle", burst_start, 0);
        chk("R8 dec 4", remaining, 6);
        beat(3'd4);
        chk("R8 dec 4 again", remaining, 2);
        chk("R9 no early done", xfer_done, 0);
        beat(3'd4);
        chk("R8 saturating dec", remaining, 0);
        chk("R9 done pulse", xfer_done, 1);
        chk("R9 tc set", tc_flag, 1);
        chk("R9 intr bus service", intr_code, 8'h10);
        chk("R9 count cleared", count_rd, 0);
        chk("R9 busy low", xfer_busy, 0);
        beat(3'd5);
        chk("R9 done one cycle", xfer_done, 0);
        chk("R8 idle beat ignored", remaining, 0);
        chk("R8 idle beat tc kept", tc_flag, 1);
    endtask

    task automatic t_tc_clear;
        hwrite(4'h0, 8'd5);
        chk("R3 tc cleared by count write", tc_flag, 0);
        chk("R2 count_rd unchanged", count_rd, 0);
        hwrite(4'h0, 8'd8);
        hwrite(4'h1, 8'd0);
        phase_resid = 18'd0;
        hwrite(4'h3, 8'h90);
        chk("R10 start pulse", burst_start, 1);
        chk("R10 zero len", burst_len, 0);
        chk("R10 immediate done", xfer_done, 1);
        chk("R10 tc set", tc_flag, 1);
        chk("R10 not busy", xfer_busy, 0);
    endtask

    task automatic t_lengths;
        hwrite(4'h0, 8'h00);
        hwrite(4'h1, 8'h00);
        phase_resid = 18'd100000;
        hwrite(4'h3, 8'h90);
        chk("R5 zero count is 65536", burst_len, 65536);
        chk("R5 tc cleared on start", tc_flag, 0);
        hwrite(4'h1, 8'h10);
        phase_resid = -18'sd300;
        hwrite(4'h3, 8'h90);
        chk("R11 negative residual", burst_len, 300);
        cmd_collect = 1'b1;
        hwrite(4'h3, 8'h90);
        chk("R6 cap 32", burst_len, 32);
        hwrite(4'h0, 8'd20);
        hwrite(4'h1, 8'd0);
        hwrite(4'h3, 8'h90);
        chk("R6 count below cap", burst_len, 20);
        cmd_collect = 1'b0;
        hwrite(4'h3, 8'h10);
        chk("R7 no start without bit7", burst_start, 0);
        chk("R7 len kept", burst_len, 20);
        chk("R7 dma_mode low", dma_mode, 0);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shadow();
        t_burst_complete();
        t_tc_clear();
        t_lengths();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule